// File: doc/BRIEF.md
# Second-Order Recursive Filter Section

This block is one second-order recursive filter section in transposed canonical form. Each accepted input strobe carries one signed 16-bit fixed-point sample with 15 fractional bits. The section answers with one output sample of the same format and raises a single-cycle valid pulse. A single shared multiplier computes the section's five products over a fixed sequence of clock cycles. The two delay states are held at full accumulator width between samples and are never truncated.

Three feed-forward and two feedback coefficients are written through a narrow write port that selects one coefficient per write. The leading denominator term is always one. A combinational checker tests the loaded feedback pair against the second-order stability triangle. While that check fails, the section copies its input to its output, so a bad setting never drives the recursion. Any accepted coefficient write resets both delay states and abandons a sample that is being computed.

Top module: `iir2_section`

## Requirements
- R1: After reset, out_vld is low, out_y is 0, all five coefficients are 0 and stable is high, so the first sample produces an output of 0.
- R2: A write with coef_wr high stores coef_data into the coefficient chosen by coef_sel: 0 selects b0, 1 selects b1, 2 selects b2, 3 selects a1 and 4 selects a2. The b0, b1, b2 and a2 coefficients are two's-complement with 15 fractional bits. The a1 coefficient is two's-complement with 14 fractional bits, which gives a range of -2 to just under 2.
- R3: For each sample x, the section forms yw = b0·x + s1 at 30 fractional bits and turns it into the 16-bit output y. It then updates s1 to b1·x − a1·y + s2 and s2 to b2·x − a2·y. Both states are kept at 30 fractional bits in 40-bit registers, and both updates use the rounded and saturated y.
- R4: y is yw shifted right by 15 bits after 2^14 is added, which rounds to nearest with ties toward positive infinity.
- R5: If the rounded value is above 32767, y is 32767. If it is below -32768, y is -32768. The output never wraps.
- R6: stable is high only when a2 ≠ -1 (code 0x8000), 1 + a1 + a2 > 0 and 1 − a1 + a2 > 0. A case exactly on the boundary (sum equal to 0) is unstable.
- R7: While stable is low, out_y equals the input sample, with the same timing as normal operation, and s1 and s2 do not change.
- R8: A write with coef_sel from 0 to 4 clears s1 and s2 and abandons any sample in progress, with no out_vld pulse for that sample. A write with coef_sel from 5 to 7 changes nothing: no coefficient, no state and no stable flag.
- R9: A strobe accepted at clock edge n gives a one-cycle out_vld pulse after edge n+5. out_y then holds until the next result. An in_vld strobe that arrives while a sample is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| coef_wr | input | 1 | Coefficient write strobe |
| coef_sel | input | 3 | Coefficient select code |
| coef_data | input | 16 | Coefficient value |
| in_vld | input | 1 | Input sample strobe |
| in_x | input | 16 | Input sample, signed, 15 fractional bits |
| out_vld | output | 1 | One-cycle output valid pulse |
| out_y | output | 16 | Output sample, signed, 15 fractional bits |
| stable | output | 1 | High when the loaded feedback pair is inside the stability triangle |

## Verification
The hardest behaviour to observe is the handling of the delay states, because s1 and s2 never appear at a port. To reach them, the stimulus first pushes a large sample through a nonzero b1, which leaves a known residue in s1. It then writes a coefficient, either with a valid select code or with an unused one, and feeds a zero sample. A cleared state gives 0 at the output. A retained state gives exactly the residue. Saturation of the feedback path is reached in a similar way: two full-scale samples in a row with b0 and b1 both near one make yw roughly double the output range.

// File: rtl/iir2_pkg.sv
package iir2_pkg;

  localparam int CSEL_W   = 3;
  localparam int NUM_COEF = 5;

  localparam logic [CSEL_W-1:0] SEL_B0 = 3'd0;
  localparam logic [CSEL_W-1:0] SEL_B1 = 3'd1;
  localparam logic [CSEL_W-1:0] SEL_B2 = 3'd2;
  localparam logic [CSEL_W-1:0] SEL_A1 = 3'd3;
  localparam logic [CSEL_W-1:0] SEL_A2 = 3'd4;

  // Multiply-accumulate sequence, one product per state
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_Y    = 3'd1,
    ST_S1A  = 3'd2,
    ST_S1B  = 3'd3,
    ST_S2A  = 3'd4,
    ST_S2B  = 3'd5
  } mac_st_e;

endpackage

// File: rtl/iir2_coef_bank.sv
module iir2_coef_bank
  import iir2_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [CSEL_W-1:0]        sel,
  input  logic [DATA_W-1:0]        wdata,
  output logic signed [DATA_W-1:0] b0,
  output logic signed [DATA_W-1:0] b1,
  output logic signed [DATA_W-1:0] b2,
  output logic signed [DATA_W-1:0] a1,
  output logic signed [DATA_W-1:0] a2,
  output logic                     clr
);

  logic [DATA_W-1:0] coef_q [NUM_COEF];
  logic [DATA_W-1:0] coef_n [NUM_COEF];
  logic [NUM_COEF-1:0] en;

  for (genvar i = 0; i < NUM_COEF; i++) begin : g_coef
    always_comb begin
      en[i]     = wr && (sel == CSEL_W'(i));
      coef_n[i] = en[i] ? wdata : coef_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) coef_q[i] <= '0;
      else        coef_q[i] <= coef_n[i];
    end
  end

  always_comb begin
    clr = |en;
    b0  = $signed(coef_q[SEL_B0]);
    b1  = $signed(coef_q[SEL_B1]);
    b2  = $signed(coef_q[SEL_B2]);
    a1  = $signed(coef_q[SEL_A1]);
    a2  = $signed(coef_q[SEL_A2]);
  end

  // R8: an unused select code leaves every coefficient untouched
  assert_ignore_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel > SEL_A2) |=> ($stable(b0) && $stable(b1) && $stable(b2) &&
                              $stable(a1) && $stable(a2)));

  // R2: a write to a1 lands in a1 on the next cycle
  assert_load_a1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_A1) |=> (a1 == $signed($past(wdata))));

endmodule

// File: rtl/iir2_stab_chk.sv
module iir2_stab_chk #(
  parameter int DATA_W = 16
) (
  input  logic signed [DATA_W-1:0] a1,
  input  logic signed [DATA_W-1:0] a2,
  output logic                     stable
);

  localparam int CW = DATA_W + 3;
  localparam logic signed [CW-1:0] ONE = CW'(64'd1 << (DATA_W - 1));
  localparam logic [DATA_W-1:0] A2_NEG_ONE = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [CW-1:0] a1x2, a2x, sum_p, sum_m;

  always_comb begin
    // a1 carries one fewer fraction bit, so double it to align with a2
    a1x2   = {{2{a1[DATA_W-1]}}, a1, 1'b0};
    a2x    = {{3{a2[DATA_W-1]}}, a2};
    sum_p  = ONE + a1x2 + a2x;
    sum_m  = ONE - a1x2 + a2x;
    stable = (a2 != $signed(A2_NEG_ONE)) && (sum_p > 0) && (sum_m > 0);
  end

endmodule

// File: rtl/iir2_mac_dp.sv
module iir2_mac_dp
  import iir2_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     in_vld,
  input  logic [DATA_W-1:0]        in_x,
  input  logic signed [DATA_W-1:0] b0,
  input  logic signed [DATA_W-1:0] b1,
  input  logic signed [DATA_W-1:0] b2,
  input  logic signed [DATA_W-1:0] a1,
  input  logic signed [DATA_W-1:0] a2,
  input  logic                     stable,
  output logic                     out_vld,
  output logic [DATA_W-1:0]        out_y
);

  localparam int PROD_W = 2 * DATA_W;
  localparam int FRAC   = DATA_W - 1;
  localparam logic signed [ACC_W-1:0] Y_MAX = ACC_W'((64'd1 << FRAC) - 64'd1);
  localparam logic signed [ACC_W-1:0] Y_MIN = -Y_MAX - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] RND   = ACC_W'(64'd1 << (FRAC - 1));

  mac_st_e st_q, st_n;
  logic signed [DATA_W-1:0] xr_q, xr_n, yr_q, yr_n, oy_q, oy_n;
  logic signed [ACC_W-1:0]  s1_q, s1_n, s2_q, s2_n, acc_q, acc_n;
  logic                     ov_q, ov_n;

  logic signed [DATA_W-1:0] m_coef, m_op, yq;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_x, ysum, yrnd;

  // Operand selection for the shared multiplier
  always_comb begin
    unique case (st_q)
      ST_S1A:  begin m_coef = b1; m_op = xr_q; end
      ST_S1B:  begin m_coef = a1; m_op = yr_q; end
      ST_S2A:  begin m_coef = b2; m_op = xr_q; end
      ST_S2B:  begin m_coef = a2; m_op = yr_q; end
      default: begin m_coef = b0; m_op = xr_q; end
    endcase
    prod   = m_coef * m_op;
    prod_x = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    ysum   = prod_x + s1_q;
    yrnd   = (ysum + RND) >>> FRAC;
    if (yrnd > Y_MAX)      yq = Y_MAX[DATA_W-1:0];
    else if (yrnd < Y_MIN) yq = Y_MIN[DATA_W-1:0];
    else                   yq = yrnd[DATA_W-1:0];
  end

  // Next-state logic
  always_comb begin
    st_n  = st_q;
    xr_n  = xr_q;
    yr_n  = yr_q;
    oy_n  = oy_q;
    s1_n  = s1_q;
    s2_n  = s2_q;
    acc_n = acc_q;
    ov_n  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (in_vld) begin
        xr_n = $signed(in_x);
        st_n = ST_Y;
      end
      ST_Y: begin
        yr_n = stable ? yq : xr_q;
        st_n = ST_S1A;
      end
      ST_S1A: begin
        acc_n = prod_x + s2_q;
        st_n  = ST_S1B;
      end
      ST_S1B: begin
        // a1 has 14 fraction bits: one left shift restores alignment
        if (stable) s1_n = acc_q - (prod_x <<< 1);
        st_n = ST_S2A;
      end
      ST_S2A: begin
        acc_n = prod_x;
        st_n  = ST_S2B;
      end
      ST_S2B: begin
        if (stable) s2_n = acc_q - prod_x;
        oy_n = yr_q;
        ov_n = 1'b1;
        st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
    if (clr) begin
      s1_n = '0;
      s2_n = '0;
      ov_n = 1'b0;
      oy_n = oy_q;
      st_n = ST_IDLE;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      xr_q  <= '0;
      yr_q  <= '0;
      oy_q  <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
      acc_q <= '0;
      ov_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      xr_q  <= xr_n;
      yr_q  <= yr_n;
      oy_q  <= oy_n;
      s1_q  <= s1_n;
      s2_q  <= s2_n;
      acc_q <= acc_n;
      ov_q  <= ov_n;
    end
  end

  always_comb begin
    out_vld = ov_q;
    out_y   = oy_q;
  end

  // R9: the valid pulse lasts one cycle and closes the sequence
  assert_vld_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q |=> !ov_q);
  assert_vld_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q |-> ($past(st_q) == ST_S2B));

  // R8: a coefficient load empties both delay states
  assert_state_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (s1_q == '0 && s2_q == '0 && st_q == ST_IDLE));

  // R7: with an unstable denominator the output copies the sample
  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !stable) |-> (oy_q == xr_q));

  // R5: out-of-range results clip to the end of the range
  assert_sat_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_Y && stable && yrnd > Y_MAX) |=> (yr_q == Y_MAX[DATA_W-1:0]));
  assert_sat_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_Y && stable && yrnd < Y_MIN) |=> (yr_q == Y_MIN[DATA_W-1:0]));

endmodule

// File: rtl/iir2_section.sv
module iir2_section
  import iir2_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              coef_wr,
  input  logic [CSEL_W-1:0] coef_sel,
  input  logic [DATA_W-1:0] coef_data,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_x,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_y,
  output logic              stable
);

  logic [1:0] rsync_q;
  logic       rst_i_n;
  logic       clr;
  logic signed [DATA_W-1:0] b0, b1, b2, a1, a2;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  iir2_coef_bank #(.DATA_W(DATA_W)) u_coef (
    .clk   (clk),
    .rst_n (rst_i_n),
    .wr    (coef_wr),
    .sel   (coef_sel),
    .wdata (coef_data),
    .b0    (b0),
    .b1    (b1),
    .b2    (b2),
    .a1    (a1),
    .a2    (a2),
    .clr   (clr)
  );

  iir2_stab_chk #(.DATA_W(DATA_W)) u_stab (
    .a1     (a1),
    .a2     (a2),
    .stable (stable)
  );

  iir2_mac_dp #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .clr     (clr),
    .in_vld  (in_vld),
    .in_x    (in_x),
    .b0      (b0),
    .b1      (b1),
    .b2      (b2),
    .a1      (a1),
    .a2      (a2),
    .stable  (stable),
    .out_vld (out_vld),
    .out_y   (out_y)
  );

  // R6: a2 of exactly -1 can never be reported as stable
  assert_a2_edge_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (a2 == $signed({1'b1, {(DATA_W-1){1'b0}}})) |-> !stable);

endmodule

// File: tb/iir2_section_tb.sv
module iir2_section_tb;

  logic        clk;
  logic        rst_n;
  logic        coef_wr;
  logic [2:0]  coef_sel;
  logic [15:0] coef_data;
  logic        in_vld;
  logic [15:0] in_x;
  logic        out_vld;
  logic [15:0] out_y;
  logic        stable;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench-side reference state
  longint mb0, mb1, mb2, ma1, ma2, ms1, ms2;

  iir2_section u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .coef_wr   (coef_wr),
    .coef_sel  (coef_sel),
    .coef_data (coef_data),
    .in_vld    (in_vld),
    .in_x      (in_x),
    .out_vld   (out_vld),
    .out_y     (out_y),
    .stable    (stable)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit ref_stable();
    return (ma2 != -32768) && (32768 + 2 * ma1 + ma2 > 0) &&
           (32768 - 2 * ma1 + ma2 > 0);
  endfunction

  task automatic ref_step(input longint x, output longint y);
    longint yw, yr;
    yw = mb0 * x + ms1;
    yr = (yw + 16384) >>> 15;
    if (yr > 32767) yr = 32767;
    if (yr < -32768) yr = -32768;
    if (!ref_stable()) begin
      y = x;
    end else begin
      y   = yr;
      ms1 = mb1 * x + ms2 - 2 * ma1 * yr;
      ms2 = mb2 * x - ma2 * yr;
    end
  endtask

  task automatic write_coef(input logic [2:0] sel, input logic [15:0] val);
    @(negedge clk);
    coef_wr = 1'b1; coef_sel = sel; coef_data = val;
    @(negedge clk);
    coef_wr = 1'b0;
    case (sel)
      3'd0: mb0 = longint'($signed(val));
      3'd1: mb1 = longint'($signed(val));
      3'd2: mb2 = longint'($signed(val));
      3'd3: ma1 = longint'($signed(val));
      3'd4: ma2 = longint'($signed(val));
      default: ;
    endcase
    if (sel <= 3'd4) begin ms1 = 0; ms2 = 0; end
  endtask

  task automatic load_all(input logic [15:0] c0, input logic [15:0] c1,
                          input logic [15:0] c2, input logic [15:0] d1,
                          input logic [15:0] d2);
    write_coef(3'd0, c0);
    write_coef(3'd1, c1);
    write_coef(3'd2, c2);
    write_coef(3'd3, d1);
    write_coef(3'd4, d2);
  endtask

  // drives one sample, returns output and edges to out_vld
  task automatic run_sample(input longint x, output longint y, output int lat);
    @(negedge clk);
    in_vld = 1'b1; in_x = x[15:0];
    lat = 0;
    for (int k = 1; k <= 20; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 1) in_vld = 1'b0;
      if (out_vld) begin lat = k; break; end
    end
    y = longint'($signed(out_y));
  endtask

  task automatic sample_check(input string tag, input longint x);
    longint got, exp;
    int lat;
    run_sample(x, got, lat);
    ref_step(x, exp);
    chk(tag, got, exp);
  endtask

  task automatic t_reset();
    chk("R1 out_vld after reset", out_vld, 0);
    chk("R1 out_y after reset", out_y, 0);
    chk("R1 stable after reset", stable, 1);
    sample_check("R1 zero coefficients give zero", 12000);
  endtask

  task automatic t_scale_round();
    load_all(16'h4000, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    sample_check("R2 half gain", 1000);
    chk("R2 half gain literal", $signed(out_y), 500);
    sample_check("R4 round tie up positive", 3);
    chk("R4 3*0.5 literal", $signed(out_y), 2);
    sample_check("R4 round tie up negative", -3);
    chk("R4 -3*0.5 literal", $signed(out_y), -1);
    sample_check("R4 negative full scale", -32768);
  endtask

  task automatic t_biquad();
    // a1 = -1.0 in 14-fraction form, a2 = 0.5
    load_all(16'h2000, 16'h4000, 16'h2000, 16'hC000, 16'h4000);
    chk("R6 biquad set stable", stable, 1);
    sample_check("R3 impulse head", 20000);
    for (int i = 0; i < 8; i++) sample_check("R3 impulse tail", 0);
    for (int i = 0; i < 6; i++) sample_check("R3 step response", 5000);
    sample_check("R3 negative swing", -25000);
    sample_check("R3 negative swing 2", -25000);
  endtask

  task automatic t_saturate();
    load_all(16'h7FFF, 16'h7FFF, 16'h0000, 16'h0000, 16'h0000);
    sample_check("R5 first full scale", 32767);
    sample_check("R5 upper clip", 32767);
    chk("R5 upper clip literal", $signed(out_y), 32767);
    write_coef(3'd1, 16'h7FFF);
    sample_check("R5 first negative full scale", -32768);
    sample_check("R5 lower clip", -32768);
    chk("R5 lower clip literal", $signed(out_y), -32768);
  endtask

  task automatic t_stability();
    write_coef(3'd3, 16'd16384); write_coef(3'd4, 16'h0000);
    chk("R6 a1=+1 boundary", stable, 0);
    write_coef(3'd3, 16'd16383);
    chk("R6 a1 just below +1", stable, 1);
    write_coef(3'd3, 16'hC000);
    chk("R6 a1=-1 boundary", stable, 0);
    write_coef(3'd3, 16'h0000); write_coef(3'd4, 16'h8000);
    chk("R6 a2=-1", stable, 0);
    write_coef(3'd3, 16'h8000); write_coef(3'd4, 16'h7FFF);
    chk("R6 a1=-2 a2 near 1", stable, 0);
    write_coef(3'd3, 16'h0000); write_coef(3'd4, 16'h7FFF);
    chk("R6 a2 near 1 alone", stable, 1);
  endtask

  task automatic t_bypass();
    load_all(16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h0000, 16'h8000);
    chk("R7 unstable flag", stable, 0);
    sample_check("R7 passthrough", 12345);
    chk("R7 passthrough literal", $signed(out_y), 12345);
    sample_check("R7 passthrough negative", -7);
    write_coef(3'd4, 16'h0000);
    sample_check("R7 states untouched during bypass", 0);
    chk("R7 zero after leaving bypass", $signed(out_y), 0);
  endtask

  task automatic t_clear();
    load_all(16'h4000, 16'h4000, 16'h0000, 16'h0000, 16'h0000);
    sample_check("R8 build state", 10000);
    write_coef(3'd0, 16'h4000);
    sample_check("R8 state cleared by load", 0);
    chk("R8 cleared literal", $signed(out_y), 0);
    sample_check("R8 build state again", 10000);
    write_coef(3'd5, 16'h1234);
    chk("R8 unused code keeps stable", stable, 1);
    sample_check("R8 unused code keeps state", 0);
    chk("R8 retained literal", $signed(out_y), 5000);
    sample_check("R8 unused code keeps b0", 1000);
  endtask

  task automatic t_timing();
    longint got, exp;
    int lat, pulses;
    load_all(16'h4000, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    run_sample(2000, got, lat);
    ref_step(2000, exp);
    chk("R9 latency", lat, 6);
    chk("R9 value", got, exp);
    @(negedge clk);
    chk("R9 single cycle pulse", out_vld, 0);
    chk("R9 out_y holds", $signed(out_y), exp);
    // a strobe during the sequence must be dropped
    pulses = 0;
    @(negedge clk);
    in_vld = 1'b1; in_x = 16'd4000;
    for (int k = 1; k <= 14; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 1) in_vld = 1'b0;
      if (k == 2) begin in_vld = 1'b1; in_x = 16'd8000; end
      if (k == 3) in_vld = 1'b0;
      if (out_vld) begin
        pulses++;
        chk("R9 busy strobe value", $signed(out_y), 2000);
      end
    end
    chk("R9 busy strobe ignored", pulses, 1);
    // a load in mid-sequence abandons the sample
    pulses = 0;
    @(negedge clk);
    in_vld = 1'b1; in_x = 16'd4000;
    @(negedge clk);
    in_vld = 1'b0;
    write_coef(3'd0, 16'h4000);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (out_vld) pulses++;
    end
    chk("R8 load aborts sample", pulses, 0);
  endtask

  initial begin
    rst_n = 1'b0; coef_wr = 1'b0; coef_sel = '0; coef_data = '0;
    in_vld = 1'b0; in_x = '0;
    mb0 = 0; mb1 = 0; mb2 = 0; ma1 = 0; ma2 = 0; ms1 = 0; ms2 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_scale_round();
    t_biquad();
    t_saturate();
    t_stability();
    t_bypass();
    t_clear();
    t_timing();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule